// File: doc/BRIEF.md
# UART Automatic Baud Rate Detector

This block watches a raw serial receive line and works out the host's bit rate without any preconfigured divisor. After a start pulse, the host repeatedly sends the byte 0x00. With 8N1 framing, each such byte holds the line low for nine bit times: the start bit and eight zero data bits. The block times that low stretch in system clock cycles.

The block compares each measurement with the one before it. When two consecutive measurements agree closely, it converts the later one into a divisor for a 16x oversampling UART and loads that value into its divisor output. It then raises a locked flag and asks the companion transmitter to send one 0x00 byte back to the host as the acknowledgement.

Some events stop or restart the search. A line held low past the counter's range is treated as a break and discarded. A rate too fast for the oversampling receiver ends the search with an error flag. The error flag and the locked flag both hold until the next start pulse or reset.

Top module: `autobaud_lock`

## Requirements
- R1: After reset, `divisor_o` is 0 and `locked_o`, `error_o` and `tx_req_o` are 0. Nothing is measured until a start pulse arrives.
- R2: A measurement is the number of clock cycles the synchronised receive line stays low, from a falling edge up to the next rising edge.
- R3: On lock, `divisor_o` = floor((L + 72) / 144) - 1, where L is the later of the two agreeing measurements. This is the per-bit period L/9 divided by 16, rounded to nearest, minus one.
- R4: The block locks only when |L2 - L1| * 100 < 3 * L1, where L1 is the stored reference and L2 is the new measurement. If the two do not agree, L2 becomes the new reference and the search continues.
- R5: A low period longer than 2^CNT_W - 1 cycles is a break. The block discards it together with any stored reference, and measuring resumes once the line returns high.
- R6: If two agreeing measurements give floor((L + 72) / 144) < 2, the block sets `error_o`. In that case `locked_o` stays 0 and `divisor_o` keeps its old value. The error holds until a start pulse, and further receive activity is ignored meanwhile.
- R7: Each lock produces exactly one single-cycle `tx_req_o` pulse, and `tx_byte_o` reads 0x00 during that pulse.
- R8: `locked_o` stays 1 until reset or a start pulse. While locked, receive activity changes neither `divisor_o` nor `tx_req_o`.
- R9: A start pulse clears `locked_o` and `error_o` and begins a fresh search with no stored reference. A low period already in progress when the pulse arrives is not measured.
- R10: Before the first start pulse, receive activity has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a new search |
| rx_i | input | 1 | Raw serial receive line, idle high |
| divisor_o | output | CNT_W | Baud divisor for a 16x oversampling UART |
| locked_o | output | 1 | Divisor valid and loaded |
| error_o | output | 1 | Measured rate too fast to encode |
| tx_req_o | output | 1 | One-cycle request to transmit tx_byte_o |
| tx_byte_o | output | 8 | Byte to transmit (always 0x00 acknowledge) |

## Verification
The bench goes after the tolerance edge. With a pair 4000/3880 the difference is exactly 3 percent, and a design using a non-strict comparison would lock there. It checks that a rejected measurement replaces the reference: a design that kept the first reference would never lock on the 1440, 1490, 1490 sequence. It checks that a break clears the reference, so one good byte after a break must not lock. It also starts a search while the line is already low, where a design counting the partial stretch would lock one byte early. The bench probes the divisor floor at lengths 216 and 215, where a wrong rounding or error limit shows up as a false lock or a missing error. It also confirms that the error and lock states are sticky.

// File: rtl/abd_pkg.sv
package abd_pkg;
  typedef enum logic [1:0] {
    M_WAIT_HIGH,
    M_IDLE,
    M_LOW
  } meter_state_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_CHECK,
    ST_LOCKED,
    ST_ERROR
  } ctrl_state_e;
endpackage

// File: rtl/abd_sync.sv
module abd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  // reset to idle-high so no false falling edge appears after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/abd_low_meter.sv
module abd_low_meter
  import abd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             rx_i,
  output logic             done_o,
  output logic             brk_o,
  output logic [CNT_W-1:0] len_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  meter_state_e     st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= M_WAIT_HIGH;
      cnt_q  <= '0;
      done_o <= 1'b0;
      brk_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      brk_o  <= 1'b0;
      if (!arm_i) begin
        st_q <= M_WAIT_HIGH;    // a low already in progress is never timed
      end else begin
        unique case (st_q)
          M_WAIT_HIGH: if (rx_i) st_q <= M_IDLE;
          M_IDLE: if (!rx_i) begin
            cnt_q <= CNT_W'(1);
            st_q  <= M_LOW;
          end
          M_LOW: begin
            if (rx_i) begin
              done_o <= 1'b1;
              st_q   <= M_IDLE;
            end else if (cnt_q == CNT_MAX) begin
              brk_o <= 1'b1;
              st_q  <= M_WAIT_HIGH;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          default: st_q <= M_WAIT_HIGH;
        endcase
      end
    end
  end

  assign len_o = cnt_q;

  p_done_brk_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && brk_o));
  p_brk_needs_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> (len_o == CNT_MAX));
endmodule

// File: rtl/abd_match.sv
module abd_match #(
  parameter int CNT_W   = 16,
  parameter int TOL_PCT = 3
) (
  input  logic [CNT_W-1:0] ref_i,
  input  logic [CNT_W-1:0] new_i,
  output logic             ok_o
);
  localparam int PW = CNT_W + 7;

  logic [CNT_W-1:0] diff;
  logic [PW-1:0]    lhs, rhs;

  always_comb begin
    diff = (ref_i > new_i) ? (ref_i - new_i) : (new_i - ref_i);
    lhs  = PW'(diff) * PW'(100);
    rhs  = PW'(ref_i) * PW'(TOL_PCT);
    ok_o = lhs < rhs;
  end
endmodule

// File: rtl/abd_divcalc.sv
module abd_divcalc #(
  parameter int CNT_W      = 16,
  parameter int OVS        = 16,
  parameter int FRAME_BITS = 9
) (
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] div_o,
  output logic             small_o
);
  localparam int STEP = OVS * FRAME_BITS;
  localparam int HALF = STEP / 2;

  logic [CNT_W:0] sum, quo;

  always_comb begin
    sum     = {1'b0, len_i} + (CNT_W+1)'(HALF);
    quo     = sum / (CNT_W+1)'(STEP);
    small_o = quo < (CNT_W+1)'(2);
    div_o   = quo[CNT_W-1:0] - CNT_W'(1);
  end
endmodule

// File: rtl/autobaud_lock.sv
module autobaud_lock
  import abd_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int OVS         = 16,
  parameter int FRAME_BITS  = 9,
  parameter int TOL_PCT     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rx_i,
  output logic [CNT_W-1:0] divisor_o,
  output logic             locked_o,
  output logic             error_o,
  output logic             tx_req_o,
  output logic [7:0]       tx_byte_o
);
  localparam logic [7:0] ACK_BYTE = 8'h00;

  ctrl_state_e      st_q;
  logic             rx_s, arm, done, brk, match_ok, too_small;
  logic [CNT_W-1:0] len, ref_q, div_calc;

  abd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(rx_s)
  );

  assign arm = ((st_q == ST_HUNT) || (st_q == ST_CHECK)) && !start_i;

  abd_low_meter #(.CNT_W(CNT_W)) u_meter (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm), .rx_i(rx_s),
    .done_o(done), .brk_o(brk), .len_o(len)
  );

  abd_match #(.CNT_W(CNT_W), .TOL_PCT(TOL_PCT)) u_match (
    .ref_i(ref_q), .new_i(len), .ok_o(match_ok)
  );

  abd_divcalc #(.CNT_W(CNT_W), .OVS(OVS), .FRAME_BITS(FRAME_BITS)) u_div (
    .len_i(len), .div_o(div_calc), .small_o(too_small)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ref_q     <= '0;
      divisor_o <= '0;
      locked_o  <= 1'b0;
      error_o   <= 1'b0;
      tx_req_o  <= 1'b0;
    end else begin
      tx_req_o <= 1'b0;
      if (start_i) begin
        st_q     <= ST_HUNT;
        locked_o <= 1'b0;
        error_o  <= 1'b0;
      end else begin
        unique case (st_q)
          ST_HUNT: if (done) begin
            ref_q <= len;
            st_q  <= ST_CHECK;
          end
          ST_CHECK: begin
            if (brk) begin
              st_q <= ST_HUNT;           // break drops the reference
            end else if (done) begin
              if (!match_ok) begin
                ref_q <= len;
              end else if (too_small) begin
                error_o <= 1'b1;
                st_q    <= ST_ERROR;
              end else begin
                divisor_o <= div_calc;
                locked_o  <= 1'b1;
                tx_req_o  <= 1'b1;
                st_q      <= ST_LOCKED;
              end
            end
          end
          default: ;                     // IDLE, LOCKED, ERROR wait for start
        endcase
      end
    end
  end

  assign tx_byte_o = ACK_BYTE;

  p_tx_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |=> !tx_req_o);
  p_lock_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> tx_req_o);
  p_lock_err_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(locked_o && error_o));
  p_start_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!locked_o && !error_o));
  p_div_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && !start_i) |=> $stable(divisor_o));
  p_div_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> (divisor_o != '0));
endmodule

// File: tb/sim_autobaud_lock.sv
module sim_autobaud_lock;
  localparam int CNT_W = 16;
  localparam int GAP   = 200;
  localparam int NVEC  = 7;
  // {first low length, second low length, expect lock, expect divisor}
  localparam int VEC [NVEC][4] = '{
    '{1440, 1440, 1, 9},
    '{2880, 2900, 1, 19},
    '{9375, 9375, 1, 64},
    '{720,  740,  1, 4},
    '{1440, 1490, 0, 0},
    '{216,  216,  1, 1},
    '{4000, 3880, 0, 0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rx = 1'b1;
  logic [CNT_W-1:0] divisor;
  logic locked, err, tx_req;
  logic [7:0] tx_byte;
  int checks = 0, errors = 0, tx_pulses = 0, bad_bytes = 0;

  always #10 clk = ~clk;

  autobaud_lock #(.CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rx_i(rx),
    .divisor_o(divisor), .locked_o(locked), .error_o(err),
    .tx_req_o(tx_req), .tx_byte_o(tx_byte)
  );

  always @(negedge clk) if (tx_req) begin
    tx_pulses++;
    if (tx_byte != 8'h00) bad_bytes++;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic send_low(int len);
    @(negedge clk) rx = 1'b0;
    repeat (len) @(negedge clk);
    rx = 1'b1;
    repeat (GAP) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 divisor", int'(divisor), 0);
    check("R1 locked", int'(locked), 0);
    check("R1 error", int'(err), 0);
    check("R1 tx_req", int'(tx_req), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 activity before any start
    send_low(1440); send_low(1440);
    check("R10 locked", int'(locked), 0);
    check("R10 divisor", int'(divisor), 0);
    check("R10 tx pulses", tx_pulses, 0);

    // R2 R3 R4 R7 vector table
    for (int i = 0; i < NVEC; i++) begin
      p0 = tx_pulses;
      pulse_start();
      send_low(VEC[i][0]);
      send_low(VEC[i][1]);
      check("R4 lock decision", int'(locked), VEC[i][2]);
      check("R7 one ack per lock", tx_pulses - p0, VEC[i][2]);
      check("R6 no error", int'(err), 0);
      if (VEC[i][2] != 0) check("R3 divisor", int'(divisor), VEC[i][3]);
    end
    check("R7 ack byte zero", bad_bytes, 0);

    // R4 rejected measurement becomes the new reference
    pulse_start();
    send_low(1440); send_low(1490);
    check("R4 no lock after mismatch", int'(locked), 0);
    send_low(1490);
    check("R4 lock on new reference", int'(locked), 1);
    check("R3 divisor after reref", int'(divisor), 9);

    // R8 locked holds, rx ignored
    p0 = tx_pulses;
    send_low(720); send_low(720);
    check("R8 locked held", int'(locked), 1);
    check("R8 divisor held", int'(divisor), 9);
    check("R8 no extra ack", tx_pulses - p0, 0);
    pulse_start();
    check("R9 start clears lock", int'(locked), 0);

    // R6 too-fast rate, sticky error
    send_low(215); send_low(215);
    check("R6 error set", int'(err), 1);
    check("R6 locked clear", int'(locked), 0);
    check("R6 divisor kept", int'(divisor), 9);
    send_low(1440); send_low(1440);
    check("R6 error sticky", int'(err), 1);
    check("R6 still unlocked", int'(locked), 0);
    pulse_start();
    check("R9 start clears error", int'(err), 0);

    // R5 break discards reference
    send_low(2880);
    send_low(66000);
    send_low(2880);
    check("R5 no lock after break", int'(locked), 0);
    send_low(2880);
    check("R5 lock after break", int'(locked), 1);
    check("R5 divisor", int'(divisor), 19);

    // R9 low in progress at start is not timed
    @(negedge clk) rx = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (1419) @(negedge clk);
    rx = 1'b1;
    repeat (GAP) @(negedge clk);
    send_low(1440);
    check("R9 partial low ignored", int'(locked), 0);
    send_low(1440);
    check("R9 lock after fresh pair", int'(locked), 1);
    check("R9 divisor", int'(divisor), 9);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule